// File: doc/BRIEF.md
# Double-Precision to Integer Saturating Converter

This unit takes a 64-bit IEEE-754 double and turns it into a signed integer. The integer is 32 or 64 bits wide, chosen on each operation. Rounding either follows a two-bit rounding-mode input or, when a truncate input is high, is forced toward zero. The unit reports whether the integer part was rounded up in magnitude and whether any fraction was discarded. Inputs that cannot be represented saturate to the nearest end of the target range and raise an invalid-conversion flag. These are NaNs, infinities and finite values outside the range. A signalling NaN also raises a second flag.

An execution pipeline issues one conversion per `in_valid` pulse and receives the outcome one clock later. `out_wr` tells it whether the destination register may be written. When invalid traps are enabled and the input is invalid, the write is withheld, but the condition-update request still passes through. Decoding the instruction that requests the conversion happens outside this block.

Top module: `fcvt_sat`

## Requirements
- R1: `out_valid` rises exactly one clock after each cycle with `in_valid` high, and is low one clock after each cycle with `in_valid` low.
- R2: In 32-bit mode (`in_wide`=0), a NaN, or any value below -2^31 (including -infinity), gives `out_int` = 0x0000_0000_8000_0000 and sets `out_cvi`.
- R3: In 32-bit mode, any value above 2^31-1, including a value with a fraction above it and +infinity, gives `out_int` = 0x0000_0000_7FFF_FFFF and sets `out_cvi`.
- R4: In 64-bit mode (`in_wide`=1), a NaN or any value below -2^63 gives 0x8000_0000_0000_0000, and any value at or above 2^63 gives 0x7FFF_FFFF_FFFF_FFFF. Both set `out_cvi`.
- R5: A signalling NaN sets `out_snan` together with `out_cvi`. A signalling NaN has all exponent bits [62:52] set, a non-zero fraction [51:0], and fraction bit 51 clear. A quiet NaN, which has bit 51 set, sets only `out_cvi`.
- R6: On every invalid conversion, `out_fr` and `out_fi` are 0. `out_wr` equals the inverse of the `in_trap_en` value given with the operation. `out_int` still shows the saturated value.
- R7: `out_cond` equals the `in_rec` value of the operation on every completed conversion, whether or not the operation trapped.
- R8: An in-range value is rounded by `in_rmode`: 00 to nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. In 64-bit mode the result is the two's complement integer. In 32-bit mode bits [31:0] hold it and bits [63:32] are zero. `out_wr` is 1.
- R9: With `in_trunc`=1, rounding is toward zero whatever `in_rmode` holds.
- R10: For an in-range value, `out_fi` is 1 exactly when the discarded fraction is non-zero. `out_fr` is 1 exactly when the magnitude of the result exceeds the magnitude of the input.
- R11: During and after reset, `out_valid`, `out_wr`, `out_cvi`, `out_snan`, `out_fr`, `out_fi` and `out_cond` are 0.
- R12: In a clock after a cycle with `in_valid` low, `out_wr`, `out_cvi`, `out_snan` and `out_cond` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Starts a conversion this cycle |
| in_fp | input | 64 | Double-precision operand |
| in_wide | input | 1 | 1 = 64-bit integer target, 0 = 32-bit target |
| in_trunc | input | 1 | Forces rounding toward zero |
| in_rmode | input | 2 | Rounding mode (00 nearest even, 01 zero, 10 +inf, 11 -inf) |
| in_trap_en | input | 1 | Invalid-operation trap enable |
| in_rec | input | 1 | Request for a condition update |
| out_valid | output | 1 | Result present |
| out_int | output | 64 | Integer result |
| out_wr | output | 1 | Destination write permitted |
| out_fr | output | 1 | Magnitude was rounded up |
| out_fi | output | 1 | Result inexact |
| out_cvi | output | 1 | Invalid-conversion flag |
| out_snan | output | 1 | Signalling-NaN flag |
| out_cond | output | 1 | Condition update requested |

## Verification
The bench builds the unit with its default widths: a 32-bit narrow target and a 64-bit wide target. With these widths both saturation edges can be reached with exact doubles. Those are 2^31-1, 2^31-1 plus one half, -2^31, -2^31 minus one half, and ±2^63. The largest double below 2^63 can also be reached, so every overflow comparison is tested at and next to its bound. Random operands are drawn with exponents around the 32-bit and 64-bit limits and across the fraction range. This places rounding ties, discarded fractions and both overflow directions under all four rounding modes and both widths.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int EXP_W = 11;
  localparam int MAN_W = 52;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int INT_W = 64;
  localparam int FX_W  = 2 * INT_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_snan;
    logic             big;
    logic [INT_W-1:0] ipart;
    logic             guard;
    logic             sticky;
  } unpk_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [FP_W-1:0] fp,
  output unpk_t           u
);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_BIG  = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] SH_OFF   = EXP_W'(BIAS - INT_W + MAN_W);
  localparam int               SH_W     = $clog2(FX_W);

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic [MAN_W:0]   sig;
  logic [SH_W-1:0]  sh;
  logic [FX_W-1:0]  fx;

  assign expo = fp[FP_W-2:MAN_W];
  assign man  = fp[MAN_W-1:0];
  assign sig  = {(expo != '0), man};

  always_comb begin
    u.sign    = fp[FP_W-1];
    u.is_nan  = (&expo) && (|man);
    u.is_snan = (&expo) && (|man) && !man[MAN_W-1];
    u.big     = (expo >= EXP_BIG);
    sh        = SH_W'(expo - SH_OFF);
    fx        = '0;
    if (!u.big && expo >= EXP_HALF) begin
      fx = FX_W'(sig) << sh;
    end
    u.ipart  = fx[FX_W-1:INT_W];
    u.guard  = fx[INT_W-1];
    u.sticky = (expo < EXP_HALF) ? ((expo != '0) || (|man)) : (|fx[INT_W-2:0]);
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic             sign,
  input  logic [INT_W-1:0] ipart,
  input  logic             guard,
  input  logic             sticky,
  input  logic [1:0]       rmode,
  input  logic             trunc,
  output logic [INT_W-1:0] val,
  output logic             fr,
  output logic             fi
);
  rmode_e           rm;
  logic             lost;
  logic             inc;
  logic [INT_W-1:0] mag;

  always_comb begin
    rm   = trunc ? RM_ZERO : rmode_e'(rmode);
    lost = guard | sticky;
    case (rm)
      RM_NEAR: inc = guard & (sticky | ipart[0]);
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = !sign & lost;
      default: inc = sign & lost;
    endcase
    mag = ipart + INT_W'(inc);
    val = sign ? (~mag + INT_W'(1)) : mag;
    fr  = inc;
    fi  = lost;
  end
endmodule

// File: rtl/fcvt_range.sv
module fcvt_range
  import fcvt_pkg::*;
#(
  parameter int NARROW_W = 32
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             big,
  input  logic [INT_W-1:0] ipart,
  input  logic             guard,
  input  logic             sticky,
  input  logic             wide,
  output logic             sat_lo,
  output logic             sat_hi
);
  localparam logic [INT_W-1:0] LIM_N = INT_W'(1) << (NARROW_W - 1);
  localparam logic [INT_W-1:0] LIM_W = INT_W'(1) << (INT_W - 1);

  logic [INT_W-1:0] lim;
  logic [INT_W-1:0] lim_m1;
  logic             lost;
  logic             neg_bad;
  logic             pos_bad;

  always_comb begin
    lim     = wide ? LIM_W : LIM_N;
    lim_m1  = lim - INT_W'(1);
    lost    = guard | sticky;
    neg_bad = sign  & (big | (ipart > lim)    | ((ipart == lim)    & lost));
    pos_bad = !sign & (big | (ipart > lim_m1) | ((ipart == lim_m1) & lost));
    sat_lo  = is_nan | neg_bad;
    sat_hi  = !is_nan & pos_bad;
  end
endmodule

// File: rtl/fcvt_sat.sv
module fcvt_sat
  import fcvt_pkg::*;
#(
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_fp,
  input  logic             in_wide,
  input  logic             in_trunc,
  input  logic [1:0]       in_rmode,
  input  logic             in_trap_en,
  input  logic             in_rec,
  output logic             out_valid,
  output logic [INT_W-1:0] out_int,
  output logic             out_wr,
  output logic             out_fr,
  output logic             out_fi,
  output logic             out_cvi,
  output logic             out_snan,
  output logic             out_cond
);
  localparam int               PAD_W   = INT_W - NARROW_W;
  localparam logic [INT_W-1:0] MIN_W   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_W   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_N   = {{PAD_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_N   = {{PAD_W{1'b0}}, 1'b0, {(NARROW_W-1){1'b1}}};

  unpk_t            u;
  logic [INT_W-1:0] val;
  logic             fr_c, fi_c;
  logic             sat_lo, sat_hi, inv;
  logic [INT_W-1:0] res;

  fcvt_unpack u_unpack (.fp(in_fp), .u(u));

  fcvt_round u_round (
    .sign(u.sign), .ipart(u.ipart), .guard(u.guard), .sticky(u.sticky),
    .rmode(in_rmode), .trunc(in_trunc), .val(val), .fr(fr_c), .fi(fi_c)
  );

  fcvt_range #(.NARROW_W(NARROW_W)) u_range (
    .sign(u.sign), .is_nan(u.is_nan), .big(u.big), .ipart(u.ipart),
    .guard(u.guard), .sticky(u.sticky), .wide(in_wide),
    .sat_lo(sat_lo), .sat_hi(sat_hi)
  );

  always_comb begin
    inv = sat_lo | sat_hi;
    if (inv) begin
      if (in_wide) res = sat_lo ? MIN_W : MAX_W;
      else         res = sat_lo ? MIN_N : MAX_N;
    end else begin
      res = in_wide ? val : {{PAD_W{1'b0}}, val[NARROW_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_wr    <= 1'b0;
      out_fr    <= 1'b0;
      out_fi    <= 1'b0;
      out_cvi   <= 1'b0;
      out_snan  <= 1'b0;
      out_cond  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr    <= in_valid & !(inv & in_trap_en);
      out_fr    <= in_valid & !inv & fr_c;
      out_fi    <= in_valid & !inv & fi_c;
      out_cvi   <= in_valid & inv;
      out_snan  <= in_valid & u.is_snan;
      out_cond  <= in_valid & in_rec;
      if (in_valid) out_int <= res;
    end
  end
endmodule

// File: rtl/fcvt_sat_chk.sv
module fcvt_sat_chk
  import fcvt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_wide,
  input logic             in_trap_en,
  input logic             in_rec,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_wr,
  input logic             out_fr,
  input logic             out_fi,
  input logic             out_cvi,
  input logic             out_snan,
  input logic             out_cond
);
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_sat_narrow_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> (!out_cvi || (out_int[INT_W-1:32] == '0 &&
      (out_int[31:0] == 32'h7FFF_FFFF || out_int[31:0] == 32'h8000_0000))));
  p_snan_cvi_r5: assert property (@(posedge clk) disable iff (rst)
    out_snan |-> out_cvi);
  p_invalid_clear_r6: assert property (@(posedge clk) disable iff (rst)
    out_cvi |-> (!out_fr && !out_fi));
  p_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_trap_en) |=> (!out_cvi || !out_wr));
  p_cond_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_cond == $past(in_rec)));
  p_fr_fi_r10: assert property (@(posedge clk) disable iff (rst)
    out_fr |-> out_fi);
  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_wr && !out_cvi && !out_snan && !out_cond));
endmodule

bind fcvt_sat fcvt_sat_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
  .in_trap_en(in_trap_en), .in_rec(in_rec), .out_valid(out_valid),
  .out_int(out_int), .out_wr(out_wr), .out_fr(out_fr), .out_fi(out_fi),
  .out_cvi(out_cvi), .out_snan(out_snan), .out_cond(out_cond)
);

// File: tb/fcvt_sat_test.sv
`timescale 1ns/1ps
module fcvt_sat_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_wide, in_trunc, in_trap_en, in_rec;
  logic [63:0] in_fp;
  logic [1:0]  in_rmode;
  logic        out_valid, out_wr, out_fr, out_fi, out_cvi, out_snan, out_cond;
  logic [63:0] out_int;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  fcvt_sat uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fp(in_fp), .in_wide(in_wide),
    .in_trunc(in_trunc), .in_rmode(in_rmode), .in_trap_en(in_trap_en), .in_rec(in_rec),
    .out_valid(out_valid), .out_int(out_int), .out_wr(out_wr), .out_fr(out_fr),
    .out_fi(out_fi), .out_cvi(out_cvi), .out_snan(out_snan), .out_cond(out_cond)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h (in=%h)", req, act, exp, in_fp);
    end
  endtask

  task automatic predict(input logic [63:0] bits, input logic wide, trunc,
                         input logic [1:0] rm, input logic trap,
                         output logic [63:0] e_res, output logic e_cvi, e_snan,
                         e_fr, e_fi, e_wr, output logic lo, hi);
    real    b, f, af;
    longint li;
    logic   nan, inc;
    logic [1:0] eff;
    b    = $bitstoreal(bits);
    nan  = (&bits[62:52]) && (|bits[51:0]);
    e_snan = nan && !bits[51];
    if (wide) begin
      lo = nan || b < -9223372036854775808.0;
      hi = !nan && b >= 9223372036854775808.0;
    end else begin
      lo = nan || b < -2147483648.0;
      hi = !nan && b > 2147483647.0;
    end
    if (lo || hi) begin
      if (wide) e_res = lo ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
      else      e_res = lo ? 64'h0000_0000_8000_0000 : 64'h0000_0000_7FFF_FFFF;
      e_cvi = 1'b1; e_fr = 1'b0; e_fi = 1'b0; e_wr = !trap;
    end else begin
      li = longint'(b);
      if (b >= 0.0 && real'(li) > b) li = li - 1;
      if (b < 0.0 && real'(li) < b)  li = li + 1;
      f   = b - real'(li);
      af  = (f < 0.0) ? -f : f;
      eff = trunc ? 2'b01 : rm;
      case (eff)
        2'b00:   inc = (af > 0.5) || (af == 0.5 && li[0]);
        2'b01:   inc = 1'b0;
        2'b10:   inc = (f > 0.0);
        default: inc = (f < 0.0);
      endcase
      if (inc) li = (b < 0.0) ? li - 1 : li + 1;
      e_res = wide ? 64'(li) : {32'h0, 32'(li)};
      e_cvi = 1'b0; e_fr = inc; e_fi = (f != 0.0); e_wr = 1'b1;
    end
  endtask

  task automatic run_one(logic [63:0] bits, logic wide, trunc, logic [1:0] rm,
                         logic trap, rec);
    logic [63:0] e_res;
    logic e_cvi, e_snan, e_fr, e_fi, e_wr, lo, hi;
    string rtag, ftag;
    predict(bits, wide, trunc, rm, trap, e_res, e_cvi, e_snan, e_fr, e_fi, e_wr, lo, hi);
    if (lo || hi) rtag = wide ? "R4" : (lo ? "R2" : "R3");
    else          rtag = trunc ? "R9" : "R8";
    ftag = e_cvi ? "R6" : "R10";
    @(negedge clk);
    in_valid = 1'b1; in_fp = bits; in_wide = wide; in_trunc = trunc;
    in_rmode = rm; in_trap_en = trap; in_rec = rec;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 valid", 64'(out_valid), 64'd1);
    chk({rtag, " result"}, out_int, e_res);
    chk({rtag, " cvi"}, 64'(out_cvi), 64'(e_cvi));
    chk("R5 snan", 64'(out_snan), 64'(e_snan));
    chk({ftag, " fr"}, 64'(out_fr), 64'(e_fr));
    chk({ftag, " fi"}, 64'(out_fi), 64'(e_fi));
    chk("R6 wr", 64'(out_wr), 64'(e_wr));
    chk("R7 cond", 64'(out_cond), 64'(rec));
  endtask

  function automatic logic [63:0] rnd_fp();
    logic [63:0] m;
    logic [10:0] e;
    int sel;
    m   = {$urandom, $urandom};
    sel = $urandom % 10;
    case (sel)
      0:       e = 11'h7FF;
      1:       e = 11'(1023 + 30 + ($urandom % 3));
      2:       e = 11'(1023 + 62 + ($urandom % 3));
      3:       e = 11'($urandom % 1020);
      default: e = 11'(1021 + ($urandom % 66));
    endcase
    if (sel == 4) m[51:0] = {m[51:40], 40'h0};
    return {m[63], e, m[51:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_fp = '0; in_wide = 1'b0; in_trunc = 1'b0;
    in_rmode = 2'b00; in_trap_en = 1'b0; in_rec = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 valid", 64'(out_valid), 64'd0);
    chk("R11 flags", {57'd0, out_wr, out_cvi, out_snan, out_fr, out_fi, out_cond, 1'b0}, 64'd0);
    rst = 1'b0;

    run_one($realtobits(2.5), 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    run_one($realtobits(3.5), 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one($realtobits(-2.5), 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one($realtobits(-0.3), 1'b1, 1'b0, 2'b11, 1'b0, 1'b0);
    run_one($realtobits(-0.3), 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    run_one($realtobits(3.7), 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    run_one($realtobits(-3.7), 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    run_one(64'h8000_0000_0000_0000, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
    run_one(64'h0000_0000_0000_0001, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    run_one($realtobits(2147483647.0), 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    run_one($realtobits(2147483647.5), 1'b0, 1'b1, 2'b01, 1'b1, 1'b1);
    run_one($realtobits(-2147483648.0), 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    run_one($realtobits(-2147483648.5), 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
    run_one($realtobits(9223372036854775808.0), 1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
    run_one(64'h43DF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one($realtobits(-9223372036854775808.0), 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one(64'hC3E0_0000_0000_0001, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one(64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one(64'hFFF0_0000_0000_0000, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    run_one(64'h7FF8_0000_0000_0001, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    run_one(64'h7FF0_0000_0000_0001, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1);
    run_one(64'h7FF4_0000_0000_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0);

    @(negedge clk);
    chk("R1 idle valid", 64'(out_valid), 64'd0);
    chk("R12 idle flags", {60'd0, out_wr, out_cvi, out_snan, out_cond}, 64'd0);

    for (int i = 0; i < 3000; i++) begin
      run_one(rnd_fp(), 1'($urandom), 1'(($urandom % 4) == 0), 2'($urandom),
              1'($urandom), 1'($urandom));
    end

    @(negedge clk);
    chk("R12 final idle", {59'd0, out_valid, out_wr, out_cvi, out_snan, out_cond}, 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule